// File: doc/BRIEF.md
# Booth sequential signed multiplier

This block multiplies two signed two's complement operands of parameter width W and returns the full 2W-bit signed product. It recodes the multiplier on the fly, one bit pair per clock. There is one shared working register. The multiplier is loaded into its low half, partial sums build up in its high half, and one guard bit sits below bit zero. In each cycle the block adds the multiplicand to the high half, subtracts it, or leaves the high half alone. The whole register then shifts one place to the right and keeps its sign.

A request is made by raising `start` for one cycle while the block is idle. The operands are captured on that edge. `busy` stays high for exactly W cycles, and then `done` pulses for one cycle with the finished product on `product`. The product keeps its value until the next accepted request. A request raised in the same cycle as `done` is accepted, so operations can run back to back.

Top module: `booth_mul`

## Requirements
- R1: After reset, `busy`, `done` and `product` are all zero.
- R2: A `start` seen at a clock edge while `busy` is low captures `mcand` and `mplier` and sets `busy` from the next cycle on.
- R3: `busy` stays high for exactly W consecutive cycles. It then falls, and `done` is high for exactly one cycle, the first cycle with `busy` low. `done` and `busy` are never high together.
- R4: In the `done` cycle, `product` equals the signed product of the captured operands, sign-extended to 2W bits. Each bit pair of {current low bit, previous low bit} selects the step: 01 adds the multiplicand to the upper half, 10 subtracts it, and 00 or 11 leaves it unchanged.
- R5: Extreme operands give exact results. This includes the most negative value times itself, the most negative value times the most positive value, and multiplication by zero and by -1.
- R6: A `start` raised while `busy` is high is ignored. It neither changes the running result nor its timing, and it produces no extra `done`.
- R7: A `start` raised in the `done` cycle is accepted, and `busy` is high in the following cycle.
- R8: While idle, `product` holds the last result until the next accepted `start`.
- R9: Changes on `mcand` and `mplier` after the capturing edge do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request; accepted only while idle |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier |
| busy | output | 1 | High during the W iteration cycles |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2W | Signed product, held while idle |

## Verification
Completion and acceptance of a new request can happen in the same cycle. The `done` pulse of one operation and the `start` of the next both fall in the idle cycle that follows the last shift. The bench provokes this by watching for `done` at the falling edge and raising `start` at once with new operands. It then requires that the old product is correct in that cycle, that `busy` is high in the next cycle, and that the second result arrives after exactly W more busy cycles. A second collision is also tried: `start` held high in the middle of an operation must leave both the result and the cycle count untouched.

// File: rtl/booth_mul.sv
module booth_mul #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  hi, lo, m;
  logic          q;
  logic [CW-1:0] cnt;
  logic [W:0]    hi_x, m_x, sum;

  // one extra bit keeps the true sign when the most negative value is subtracted
  assign hi_x = {hi[W-1], hi};
  assign m_x  = {m[W-1], m};

  always_comb begin
    case ({lo[0], q})
      2'b01:   sum = hi_x + m_x;
      2'b10:   sum = hi_x - m_x;
      default: sum = hi_x;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi   <= '0;
      lo   <= '0;
      m    <= '0;
      q    <= 1'b0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        hi   <= '0;
        lo   <= mplier;
        q    <= 1'b0;
        m    <= mcand;
        cnt  <= CW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        hi  <= sum[W:1];
        lo  <= {sum[0], lo[W-1:1]};
        q   <= lo[0];
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign product = {hi, lo};
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);
  localparam int BW = $clog2(W + 2);
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + BW'(1);
    else           bcnt <= '0;
  end

  assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bcnt == BW'(W)));

  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(product));

  assert_ignore_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && bcnt < BW'(W - 1)) |=> busy);
endmodule

bind booth_mul booth_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .product(product)
);

// File: tb/tb_booth_mul.sv
module tb_booth_mul;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0, mplier = '0;
  logic           busy, done;
  logic [2*W-1:0] product;

  int errors = 0, checks = 0, bcount = 0;

  typedef struct {
    logic [2*W-1:0] val;
    string          tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  booth_mul #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  task automatic check(input bit ok, input string tag, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] ea, eb;
    ea = $signed(a);
    eb = $signed(b);
    return ea * eb;
  endfunction

  // driver: issue when idle, scramble operands afterwards (R9)
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    e.val = ref_mul(a, b); e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    mcand = ~a; mplier = b ^ 32'h5a5a_a5a5;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        exp_t e;
        check(bcount == W, "R3 busy length", 64'(bcount), 64'(W));
        if (sb.size() == 0) check(1'b0, "R6 unexpected done", product, '0);
        else begin
          e = sb.pop_front();
          check(product === e.val, e.tag, product, e.val);
        end
        bcount = 0;
      end
      if (busy) bcount++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [2*W-1:0] held;
    repeat (3) @(negedge clk);
    check(!busy && !done && product == '0, "R1 reset state", {62'd0, busy, done}, '0);
    rst_n = 1'b1;

    issue(32'd2, -32'sd3, "R4 2*-3");
    issue(32'd7, 32'd9, "R4 pos*pos");
    issue(-32'sd123, 32'd4567, "R4 neg*pos");
    issue(-32'sd1000, -32'sd77, "R4 neg*neg");
    issue(32'h8000_0000, 32'h8000_0000, "R5 min*min");
    issue(32'h8000_0000, 32'h7fff_ffff, "R5 min*max");
    issue(32'h7fff_ffff, 32'h7fff_ffff, "R5 max*max");
    issue(32'h8000_0000, 32'hffff_ffff, "R5 min*-1");
    issue(32'h1234_5678, 32'd0, "R5 x*0");
    issue(32'hffff_ffff, 32'hffff_ffff, "R5 -1*-1");
    issue(32'h5555_5555, 32'haaaa_aaaa, "R4 alternating bits");
    for (int i = 0; i < 20; i++) issue($urandom, $urandom, "R4 random");

    // R6: start raised mid-operation
    issue(32'd1234, -32'sd56, "R6 start while busy");
    repeat (5) @(negedge clk);
    mcand = 32'd99; mplier = 32'd99; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;

    // R7: start in the done cycle
    @(negedge clk);
    while (!done) @(negedge clk);
    begin
      exp_t e;
      mcand = -32'sd31; mplier = 32'd1001; start = 1'b1;
      e.val = ref_mul(-32'sd31, 32'd1001); e.tag = "R7 back-to-back";
      sb.push_back(e);
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R7 busy after done-cycle start", {63'd0, busy}, 64'd1);
    end

    // R8: hold while idle
    @(negedge clk);
    while (!done) @(negedge clk);
    held = product;
    repeat (10) @(negedge clk);
    check(product === held, "R8 product held", product, held);
    check(sb.size() == 0, "R6 no pending results", 64'(sb.size()), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule